// File: doc/BRIEF.md
# Debug Breakpoint Controller

This block is the debug-control logic placed next to a small processor core. A host writes and reads an 8-bit control byte. From that byte the block decides four things:

- whether the core keeps fetching instructions or stops in debug mode;
- how a decoded software-break opcode is treated;
- whether a program-counter match acts as a hardware breakpoint;
- whether a one-byte acknowledge is sent to a serial transmitter when a breakpoint halts the core.

The core, the serial link and the general counter are outside the block. It only drives their control strobes.

Two small state machines do the work.

The mode machine has two states, MODE_RUN and MODE_HALT. Its transitions are:
- MODE_RUN to MODE_HALT, on a host write with bit 7 set.
- MODE_RUN to MODE_HALT, on a break event when no host write in the same cycle clears bit 7.
- MODE_HALT to MODE_RUN, only on a host write with bit 7 clear.

The acknowledge machine has two states, ACK_IDLE and ACK_WAIT. Its transitions are:
- ACK_IDLE to ACK_WAIT, on a break event while the acknowledge enable is set.
- ACK_WAIT to ACK_IDLE, when the transmitter signals ready. That same cycle clears the acknowledge enable.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: After reset the control byte reads 00h, `fetch_halt`, `ack_send` and `core_rst_req` are 0, and `cnt_en` is 1.
- R2: Control byte layout, bit 7 down to 0: halt, break enable, acknowledge enable, break loop, PC-match break, zero break, reserved, reset. A write stores bits 7..2. Bits 1 and 0 always read 0.
- R3: `fetch_halt` equals the stored halt bit. It changes in the cycle after the write edge.
- R4: A decoded break with break enable 0 drives `brk_nop` high in the same cycle and leaves `fetch_halt` unchanged.
- R5: A decoded break with break enable 1 and break loop 0 sets `fetch_halt` from the next cycle.
- R6: A decoded break with break enable 1 and break loop 1 drives `brk_loop` high in the same cycle and does not halt.
- R7: With PC-match break set, a fetch strobe whose 16-bit PC equals the compare value sets `fetch_halt` from the next cycle. A mismatch, or a match without the strobe, does not.
- R8: A write with bit 0 set gives a one-cycle `core_rst_req` pulse in the next cycle. Writing 81h halts and resets. Writing 40h runs with breaks enabled.
- R9: A halting break with acknowledge enable set raises `ack_send` from the next cycle with `ack_byte` = FFh. `ack_send` holds until `tx_ready`, then drops, and the acknowledge enable bit reads 0.
- R10: A break arriving while an acknowledge is pending sends no second byte.
- R11: A host write clearing bit 7 in the same cycle as a break event keeps the core running.
- R12: `cnt_en` is 0 whenever PC-match break is set, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr_en | input | 1 | Host write strobe for the control byte |
| host_wr_data | input | 8 | Host write data |
| host_rd_data | output | 8 | Control byte read-back |
| brk_decoded | input | 1 | Core decoded a software-break opcode |
| fetch_stb | input | 1 | Instruction fetch strobe |
| pc | input | 16 | Current program counter |
| cmp_val | input | 16 | Counter register value, used as compare value |
| tx_ready | input | 1 | Transmitter accepts the acknowledge byte |
| fetch_halt | output | 1 | Core must stop fetching |
| brk_loop | output | 1 | Core repeats the break opcode |
| brk_nop | output | 1 | Core treats the break opcode as a no-op |
| core_rst_req | output | 1 | One-cycle reset request |
| cnt_en | output | 1 | General counter may count |
| ack_send | output | 1 | Acknowledge byte is pending |
| ack_byte | output | 8 | Acknowledge byte value |

## Verification
The in-line assertions check these rules on every cycle:
- a halting break (R5) always reaches MODE_HALT unless the host clears bit 7 in the same cycle;
- every reset pulse (R8) is traced back to a write;
- a pending acknowledge holds while the transmitter is busy and ends after one accepted byte (R9, R10);
- an ignored break (R4) leaves the halt output alone.

Only the bench scenarios can show the following:
- the read-back layout across all 256 written values (R2);
- the three-way break resolution under every enable combination;
- the PC comparison against neighbouring values (R7);
- that a second break during a pending acknowledge still sends a single byte (R10).

// File: rtl/dbg_brk_pkg.sv
`timescale 1ns/1ps
package dbg_brk_pkg;
    localparam int CTL_W = 8;

    typedef struct packed {
        logic halt;
        logic brk_en;
        logic ack_en;
        logic brk_loop;
        logic pc_brk;
        logic zero_brk;
        logic rsvd;
        logic rst;
    } ctl_t;

    typedef enum logic [0:0] {MODE_RUN, MODE_HALT} mode_st_t;
    typedef enum logic [0:0] {ACK_IDLE, ACK_WAIT} ack_st_t;
endpackage

// File: rtl/dbg_brk_resolve.sv
`timescale 1ns/1ps
module dbg_brk_resolve #(
    parameter int PC_W = 16
) (
    input  logic            halt,
    input  logic            brk_en,
    input  logic            loop_en,
    input  logic            pc_brk,
    input  logic            brk_decoded,
    input  logic            fetch_stb,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] cmp_val,
    output logic            brk_evt,
    output logic            brk_nop,
    output logic            brk_loop,
    output logic            cnt_en
);
    logic sw_halt;
    logic pc_hit;

    always_comb begin
        sw_halt  = brk_decoded & brk_en & ~loop_en;
        pc_hit   = pc_brk & fetch_stb & (pc == cmp_val);
        brk_evt  = ~halt & (sw_halt | pc_hit);
        brk_nop  = brk_decoded & ~brk_en;
        brk_loop = brk_decoded & brk_en & loop_en;
        cnt_en   = ~pc_brk;
    end
endmodule

// File: rtl/dbg_ctl_reg.sv
`timescale 1ns/1ps
module dbg_ctl_reg
    import dbg_brk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             brk_evt,
    input  logic             ack_clr,
    output ctl_t             ctl,
    output logic             rst_req
);
    localparam int FLD_W = CTL_W - 3;

    mode_st_t         mode_q, mode_d;
    logic [FLD_W-1:0] fld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (wr_en)        mode_d = wr_data[CTL_W-1] ? MODE_HALT : MODE_RUN;
                else if (brk_evt) mode_d = MODE_HALT;
            end
            MODE_HALT: begin
                if (wr_en && !wr_data[CTL_W-1]) mode_d = MODE_RUN;
            end
            default: mode_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= wr_en & wr_data[0];
            if (wr_en)        fld_q <= wr_data[CTL_W-2:2];
            else if (ack_clr) fld_q[FLD_W-2] <= 1'b0;
        end
    end

    always_comb begin
        ctl          = '0;
        ctl.halt     = (mode_q == MODE_HALT);
        ctl.brk_en   = fld_q[4];
        ctl.ack_en   = fld_q[3];
        ctl.brk_loop = fld_q[2];
        ctl.pc_brk   = fld_q[1];
        ctl.zero_brk = fld_q[0];
    end

    assert_halt_on_brk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !(wr_en && !wr_data[CTL_W-1])) |=> ctl.halt);

    assert_rst_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wr_en && wr_data[0]));
endmodule

// File: rtl/dbg_ack_fsm.sv
`timescale 1ns/1ps
module dbg_ack_fsm
    import dbg_brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic brk_evt,
    input  logic ack_en,
    input  logic tx_ready,
    output logic ack_send,
    output logic ack_clr
);
    ack_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACK_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACK_IDLE: if (brk_evt && ack_en) st_d = ACK_WAIT;
            ACK_WAIT: if (tx_ready)          st_d = ACK_IDLE;
            default:  st_d = ACK_IDLE;
        endcase
    end

    always_comb begin
        ack_send = (st_q == ACK_WAIT);
        ack_clr  = (st_q == ACK_WAIT) && tx_ready;
    end

    assert_ack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_send && !tx_ready) |=> ack_send);

    assert_single_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_send && tx_ready) |=> !ack_send);
endmodule

// File: rtl/dbg_brk_ctrl.sv
`timescale 1ns/1ps
module dbg_brk_ctrl
    import dbg_brk_pkg::*;
#(
    parameter int          PC_W     = 16,
    parameter logic [7:0]  ACK_CODE = 8'hFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr_en,
    input  logic [7:0]      host_wr_data,
    output logic [7:0]      host_rd_data,
    input  logic            brk_decoded,
    input  logic            fetch_stb,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] cmp_val,
    input  logic            tx_ready,
    output logic            fetch_halt,
    output logic            brk_loop,
    output logic            brk_nop,
    output logic            core_rst_req,
    output logic            cnt_en,
    output logic            ack_send,
    output logic [7:0]      ack_byte
);
    ctl_t ctl;
    logic brk_evt;
    logic ack_clr;

    dbg_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr_en),
        .wr_data (host_wr_data),
        .brk_evt (brk_evt),
        .ack_clr (ack_clr),
        .ctl     (ctl),
        .rst_req (core_rst_req)
    );

    dbg_brk_resolve #(.PC_W(PC_W)) u_res (
        .halt        (ctl.halt),
        .brk_en      (ctl.brk_en),
        .loop_en     (ctl.brk_loop),
        .pc_brk      (ctl.pc_brk),
        .brk_decoded (brk_decoded),
        .fetch_stb   (fetch_stb),
        .pc          (pc),
        .cmp_val     (cmp_val),
        .brk_evt     (brk_evt),
        .brk_nop     (brk_nop),
        .brk_loop    (brk_loop),
        .cnt_en      (cnt_en)
    );

    dbg_ack_fsm u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .brk_evt  (brk_evt),
        .ack_en   (ctl.ack_en),
        .tx_ready (tx_ready),
        .ack_send (ack_send),
        .ack_clr  (ack_clr)
    );

    assign host_rd_data = ctl;
    assign fetch_halt   = ctl.halt;
    assign ack_byte     = ACK_CODE;

    assert_nop_keeps_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_nop && !host_wr_en && !fetch_stb) |=> $stable(fetch_halt));

    assert_ack_en_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_send && tx_ready && !host_wr_en) |=> !host_rd_data[5]);
endmodule

// File: tb/sim_dbg_brk_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_brk_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_wr_data = '0;
    logic [7:0]  host_rd_data;
    logic        brk_decoded = 1'b0;
    logic        fetch_stb = 1'b0;
    logic [15:0] pc = '0;
    logic [15:0] cmp_val = '0;
    logic        tx_ready = 1'b0;
    logic        fetch_halt, brk_loop, brk_nop, core_rst_req, cnt_en, ack_send;
    logic [7:0]  ack_byte;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbg_brk_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_data(host_rd_data), .brk_decoded(brk_decoded), .fetch_stb(fetch_stb),
        .pc(pc), .cmp_val(cmp_val), .tx_ready(tx_ready), .fetch_halt(fetch_halt),
        .brk_loop(brk_loop), .brk_nop(brk_nop), .core_rst_req(core_rst_req),
        .cnt_en(cnt_en), .ack_send(ack_send), .ack_byte(ack_byte)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write on one edge; returns 1 ns after the following falling edge
    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_wr_data = v;
        @(negedge clk);
        host_wr_en = 1'b0;
        #1;
    endtask

    task automatic brk_case(input logic en, input logic lp, input logic ak);
        logic halts;
        halts = en & ~lp;
        wr({1'b0, en, ak, lp, 4'b0000});
        @(negedge clk);
        brk_decoded = 1'b1;
        #1;
        chk("R4 nop", {15'd0, brk_nop}, {15'd0, ~en});
        chk("R6 loop", {15'd0, brk_loop}, {15'd0, en & lp});
        @(negedge clk);
        brk_decoded = 1'b0;
        #1;
        chk("R5 halt", {15'd0, fetch_halt}, {15'd0, halts});
        chk("R9 ack_send", {15'd0, ack_send}, {15'd0, halts & ak});
        if (halts && ak) begin
            repeat (2) @(negedge clk);
            #1;
            chk("R9 held", {15'd0, ack_send}, 16'd1);
            @(negedge clk);
            tx_ready = 1'b1;
            #1;
            chk("R9 byte", {8'd0, ack_byte}, 16'h00FF);
            @(negedge clk);
            tx_ready = 1'b0;
            #1;
            chk("R9 drop", {15'd0, ack_send}, 16'd0);
            chk("R9 en clear", {15'd0, host_rd_data[5]}, 16'd0);
        end else begin
            chk("R9 en kept", {15'd0, host_rd_data[5]}, {15'd0, ak});
        end
        wr(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk("R1 rd", {8'd0, host_rd_data}, 16'h0000);
        chk("R1 halt", {15'd0, fetch_halt}, 16'd0);
        chk("R1 ack", {15'd0, ack_send}, 16'd0);
        chk("R1 rst", {15'd0, core_rst_req}, 16'd0);
        chk("R1 cnt", {15'd0, cnt_en}, 16'd1);

        // R2 R3 R8 R12 sweep of every byte
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = v[7:0];
            wr(b);
            chk("R2 readback", {8'd0, host_rd_data}, {8'd0, b & 8'hFC});
            chk("R3 halt", {15'd0, fetch_halt}, {15'd0, b[7]});
            chk("R8 pulse", {15'd0, core_rst_req}, {15'd0, b[0]});
            chk("R12 cnt_en", {15'd0, cnt_en}, {15'd0, ~b[3]});
            @(negedge clk);
            #1;
            chk("R8 one cycle", {15'd0, core_rst_req}, 16'd0);
        end
        wr(8'h00);

        // R8 commands
        wr(8'h81);
        chk("R8 81 halt", {15'd0, fetch_halt}, 16'd1);
        chk("R8 81 rst", {15'd0, core_rst_req}, 16'd1);
        wr(8'h40);
        chk("R8 40 run", {15'd0, fetch_halt}, 16'd0);
        chk("R8 40 rd", {8'd0, host_rd_data}, 16'h0040);

        // R4 R5 R6 R9 break resolution sweep
        for (int i = 0; i < 8; i++) begin
            brk_case(i[2], i[1], i[0]);
        end

        // R7 PC match
        cmp_val = 16'h1234;
        wr(8'h48);
        chk("R12 pc mode", {15'd0, cnt_en}, 16'd0);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            pc = cmp_val ^ (16'd1 << k);
            fetch_stb = 1'b1;
            @(negedge clk);
            fetch_stb = 1'b0;
            #1;
            chk("R7 mismatch", {15'd0, fetch_halt}, 16'd0);
        end
        @(negedge clk);
        pc = cmp_val;
        @(negedge clk);
        #1;
        chk("R7 no strobe", {15'd0, fetch_halt}, 16'd0);
        @(negedge clk);
        fetch_stb = 1'b1;
        @(negedge clk);
        fetch_stb = 1'b0;
        #1;
        chk("R7 match", {15'd0, fetch_halt}, 16'd1);
        wr(8'h00);

        // R11 host clear beats break event
        wr(8'h40);
        @(negedge clk);
        brk_decoded = 1'b1;
        host_wr_en = 1'b1;
        host_wr_data = 8'h40;
        @(negedge clk);
        brk_decoded = 1'b0;
        host_wr_en = 1'b0;
        #1;
        chk("R11 host wins", {15'd0, fetch_halt}, 16'd0);
        @(negedge clk);
        brk_decoded = 1'b1;
        @(negedge clk);
        brk_decoded = 1'b0;
        #1;
        chk("R11 break alone", {15'd0, fetch_halt}, 16'd1);
        wr(8'h00);

        // R10 second break while acknowledge pending
        begin
            int sent;
            sent = 0;
            wr(8'h60);
            @(negedge clk);
            brk_decoded = 1'b1;
            @(negedge clk);
            brk_decoded = 1'b0;
            wr(8'h60);
            chk("R10 resumed", {15'd0, fetch_halt}, 16'd0);
            @(negedge clk);
            brk_decoded = 1'b1;
            @(negedge clk);
            brk_decoded = 1'b0;
            #1;
            chk("R10 halted again", {15'd0, fetch_halt}, 16'd1);
            chk("R10 pending", {15'd0, ack_send}, 16'd1);
            tx_ready = 1'b1;
            for (int c = 0; c < 4; c++) begin
                @(posedge clk);
                if (ack_send) sent++;
                @(negedge clk);
            end
            tx_ready = 1'b0;
            chk("R10 one byte", sent[15:0], 16'd1);
            wr(8'h00);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule